// File: doc/BRIEF.md
# Quad Output Converter SPI Register Slave

This block is the device-side serial port of a four-channel output converter. A host talks to it in 24-bit frames with SPI mode 0 timing: SCLK idles low, the host changes MOSI on the falling edge, and the device samples on the rising edge. Every frame is framed by an active-low chip select. The block keeps a data, gain and offset word for each channel. It also keeps two 13-bit configuration words per channel: slew and output control. Two shared 13-bit words hold the main and boost settings. All of these are driven as parallel outputs to the analog and calibration logic downstream.

The SPI pins are brought into the system clock domain through a synchronizer, and all decoding runs on the system clock. For this to work, the system clock must be several times faster than SCLK. A frame changes state only when chip select rises after exactly 24 bits. Writes and reads use two different address maps.

A read takes two frames. In the first frame the host sends the read flag and the address. In the next frame the host sends a no-op word, and the device shifts the requested value out on MISO. Control writes use the top three data bits to select which configuration word the frame updates.

Top module: `qdac_spi_regs`

## Requirements
- R1: After reset, every register output and `out_en_o` are zero, MISO is low, and reading data address 0x00 or the main word returns zero.
- R2: A frame is 24 bits, MSB first. Bit 23 is the read flag, bits 20:16 are the address and bits 15:0 are the data. A write (bit 23 clear) to address ch (0 to 3) loads that channel's data word.
- R3: A write to address 0x08+ch loads the channel's gain word, and a write to 0x10+ch loads its offset word.
- R4: A write to 0x1C+ch is a control write. Data bits 15:13 select the target and bits 12:0 are the payload. Selector 0 loads the channel slew word and selector 2 loads the channel output-control word. Selector 1 loads the shared main word and selector 3 loads the shared boost word, whichever channel address is used.
- R5: Control selectors 4 to 7 change no register. Write addresses outside the data, gain, offset and control groups change no register; this includes 0x04 to 0x07, 0x0C to 0x0F and 0x14 to 0x1B.
- R6: A frame with fewer or more than 24 SCLK rising edges while chip select is low is discarded, with no register change.
- R7: A read request (bit 23 set) makes the next frame return a 24-bit word on MISO. Bits 23:16 of that word are zero and bits 15:0 hold the value. Read map: 0x00+ch data, 0x04+ch output control, 0x08+ch gain, 0x0C+ch offset, 0x14+ch slew, 0x18 status input, 0x19 main, 0x1A boost. 13-bit words are zero-extended.
- R8: Read addresses 0x10 to 0x13, 0x1B to 0x1F, and any channel index beyond the channel count return zero.
- R9: A read request does not modify registers. With no pending read, MISO stays low for the whole frame. The next frame consumes a pending read whether or not that frame is valid, and a valid write in the response frame is still applied.
- R10: A write takes effect only after chip select rises. Outputs keep their old value while chip select stays low after the 24th bit.
- R11: `out_en_o[ch]` follows bit 6 of that channel's output-control word.
- R12: The status value returned is the one present on `status_i` when the read-request frame ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select framing one transaction |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| status_i | input | 16 | Status word returned by read address 0x18 |
| dac_code_o | output | NCH*16 | Per-channel data words, channel 0 in the low bits |
| gain_code_o | output | NCH*16 | Per-channel gain words |
| offset_code_o | output | NCH*16 | Per-channel offset words |
| slew_cfg_o | output | NCH*13 | Per-channel slew configuration |
| dac_ctl_o | output | NCH*13 | Per-channel output-control words |
| main_cfg_o | output | 13 | Shared main configuration |
| boost_cfg_o | output | 13 | Shared boost configuration |
| out_en_o | output | NCH | Per-channel output enable |

## Verification
A decode error in the write path shows on the parallel outputs a few system clocks after chip select rises. Examples are a wrong address group, a wrong selector, or a bit counter that accepts the wrong frame length. The effect is a word that changed when it should not have, or one that failed to change. Errors in the read path or in the pending-read state stay hidden until the frame after the request. They then appear as a wrong or non-zero word on MISO. For this reason, every mapped and unmapped read address is swept after the registers are loaded with two different patterns.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
   localparam int FRAME_BITS  = 24;
   localparam int WORD_W      = 16;
   localparam int CFG_W       = 13;
   localparam int ADDR_W      = 5;
   localparam int RD_FLAG_POS = 23;
   localparam int ADDR_LSB    = 16;
   localparam int MAX_CH      = 4;
   localparam int OUT_EN_POS  = 6;

   typedef logic [2:0] grp_t;

   // write map groups, address bits 4:2
   localparam grp_t WG_DATA = 3'b000;
   localparam grp_t WG_GAIN = 3'b010;
   localparam grp_t WG_OFFS = 3'b100;
   localparam grp_t WG_CTRL = 3'b111;

   // read map groups, address bits 4:2
   localparam grp_t RG_DATA = 3'b000;
   localparam grp_t RG_CTRL = 3'b001;
   localparam grp_t RG_GAIN = 3'b010;
   localparam grp_t RG_OFFS = 3'b011;
   localparam grp_t RG_SLEW = 3'b101;
   localparam grp_t RG_GLOB = 3'b110;

   typedef enum logic [2:0] {
      SUB_SLEW  = 3'd0,
      SUB_MAIN  = 3'd1,
      SUB_DAC   = 3'd2,
      SUB_BOOST = 3'd3,
      SUB_SOFT  = 3'd4
   } sub_e;
endpackage

// File: rtl/qdac_spi_rx.sv
module qdac_spi_rx
   import qdac_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sclk_i,
   input  logic                  cs_n_i,
   input  logic                  mosi_i,
   input  logic [FRAME_BITS-1:0] tx_word_i,
   output logic                  miso_o,
   output logic                  frm_start_o,
   output logic                  frm_end_o,
   output logic                  frm_ok_o,
   output logic [FRAME_BITS-1:0] frm_word_o
);
   localparam int CNT_MAX = FRAME_BITS + 1;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sclk_sh, cs_sh, mosi_sh;
   logic                   sclk_s, cs_s, mosi_s;
   logic                   sclk_q, cs_q;
   logic                   sclk_rise, sclk_fall, cs_active;
   logic [CNT_W-1:0]       bit_cnt;
   logic [FRAME_BITS-1:0]  rx_sh, tx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_sh <= '0;
         cs_sh   <= '1;
         mosi_sh <= '0;
         sclk_q  <= 1'b0;
         cs_q    <= 1'b1;
      end else begin
         sclk_sh <= {sclk_sh[SYNC_STAGES-2:0], sclk_i};
         cs_sh   <= {cs_sh[SYNC_STAGES-2:0], cs_n_i};
         mosi_sh <= {mosi_sh[SYNC_STAGES-2:0], mosi_i};
         sclk_q  <= sclk_s;
         cs_q    <= cs_s;
      end
   end

   assign sclk_s      = sclk_sh[SYNC_STAGES-1];
   assign cs_s        = cs_sh[SYNC_STAGES-1];
   assign mosi_s      = mosi_sh[SYNC_STAGES-1];
   assign sclk_rise   = sclk_s & ~sclk_q;
   assign sclk_fall   = ~sclk_s & sclk_q;
   assign cs_active   = ~cs_s & ~cs_q;
   assign frm_start_o = ~cs_s & cs_q;
   assign frm_end_o   = cs_s & ~cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
      end else if (frm_start_o) begin
         bit_cnt <= '0;
         tx_sh   <= tx_word_i;
      end else if (cs_active) begin
         if (sclk_rise) begin
            rx_sh <= {rx_sh[FRAME_BITS-2:0], mosi_s};
            if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
         end
         if (sclk_fall) tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
      end
   end

   assign frm_ok_o   = frm_end_o && (bit_cnt == CNT_W'(FRAME_BITS));
   assign frm_word_o = rx_sh;
   assign miso_o     = cs_active & tx_sh[FRAME_BITS-1];
endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
   import qdac_pkg::*;
#(
   parameter int NCH = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_stb_i,
   input  logic [ADDR_W-1:0]     wr_addr_i,
   input  logic [WORD_W-1:0]     wr_data_i,
   output logic [NCH*WORD_W-1:0] data_o,
   output logic [NCH*WORD_W-1:0] gain_o,
   output logic [NCH*WORD_W-1:0] offs_o,
   output logic [NCH*CFG_W-1:0]  slew_o,
   output logic [NCH*CFG_W-1:0]  dac_o,
   output logic [CFG_W-1:0]      main_o,
   output logic [CFG_W-1:0]      boost_o
);
   grp_t             grp;
   logic [1:0]       idx;
   logic [2:0]       sub;
   logic [CFG_W-1:0] pay;
   logic [MAX_CH-1:0] ch_ok;
   logic             ctl_hit;

   assign grp = wr_addr_i[4:2];
   assign idx = wr_addr_i[1:0];
   assign sub = wr_data_i[WORD_W-1:CFG_W];
   assign pay = wr_data_i[CFG_W-1:0];

   for (genvar i = 0; i < MAX_CH; i++) begin : g_chok
      assign ch_ok[i] = (i < NCH);
   end

   assign ctl_hit = wr_stb_i && (grp == WG_CTRL) && ch_ok[idx];

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      localparam logic [1:0] MY = 2'(g);
      logic [WORD_W-1:0] d_q, g_q, o_q;
      logic [CFG_W-1:0]  s_q, c_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_q <= '0;
            g_q <= '0;
            o_q <= '0;
            s_q <= '0;
            c_q <= '0;
         end else if (wr_stb_i && idx == MY) begin
            case (grp)
               WG_DATA: d_q <= wr_data_i;
               WG_GAIN: g_q <= wr_data_i;
               WG_OFFS: o_q <= wr_data_i;
               WG_CTRL: begin
                  if (sub == SUB_SLEW) s_q <= pay;
                  else if (sub == SUB_DAC) c_q <= pay;
               end
               default: ;
            endcase
         end
      end

      assign data_o[g*WORD_W +: WORD_W] = d_q;
      assign gain_o[g*WORD_W +: WORD_W] = g_q;
      assign offs_o[g*WORD_W +: WORD_W] = o_q;
      assign slew_o[g*CFG_W +: CFG_W]   = s_q;
      assign dac_o[g*CFG_W +: CFG_W]    = c_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_o  <= '0;
         boost_o <= '0;
      end else if (ctl_hit) begin
         if (sub == SUB_MAIN) main_o <= pay;
         else if (sub == SUB_BOOST) boost_o <= pay;
      end
   end

   // R10
   no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb_i |=> $stable(data_o) && $stable(gain_o) && $stable(offs_o)
                    && $stable(slew_o) && $stable(dac_o) && $stable(main_o) && $stable(boost_o));

   // R5
   soft_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_i && grp == WG_CTRL && wr_data_i[15] |=>
         $stable(slew_o) && $stable(dac_o) && $stable(main_o) && $stable(boost_o) && $stable(data_o));
endmodule

// File: rtl/qdac_rdmux.sv
module qdac_rdmux
   import qdac_pkg::*;
#(
   parameter int NCH = 4
) (
   input  logic [ADDR_W-1:0]     rd_addr_i,
   input  logic [WORD_W-1:0]     status_i,
   input  logic [NCH*WORD_W-1:0] data_i,
   input  logic [NCH*WORD_W-1:0] gain_i,
   input  logic [NCH*WORD_W-1:0] offs_i,
   input  logic [NCH*CFG_W-1:0]  slew_i,
   input  logic [NCH*CFG_W-1:0]  dac_i,
   input  logic [CFG_W-1:0]      main_i,
   input  logic [CFG_W-1:0]      boost_i,
   output logic [WORD_W-1:0]     rd_val_o
);
   logic [WORD_W-1:0] pd [MAX_CH];
   logic [WORD_W-1:0] pg [MAX_CH];
   logic [WORD_W-1:0] po [MAX_CH];
   logic [CFG_W-1:0]  ps [MAX_CH];
   logic [CFG_W-1:0]  pc [MAX_CH];

   for (genvar i = 0; i < MAX_CH; i++) begin : g_pad
      if (i < NCH) begin : g_live
         assign pd[i] = data_i[i*WORD_W +: WORD_W];
         assign pg[i] = gain_i[i*WORD_W +: WORD_W];
         assign po[i] = offs_i[i*WORD_W +: WORD_W];
         assign ps[i] = slew_i[i*CFG_W +: CFG_W];
         assign pc[i] = dac_i[i*CFG_W +: CFG_W];
      end else begin : g_void
         assign pd[i] = '0;
         assign pg[i] = '0;
         assign po[i] = '0;
         assign ps[i] = '0;
         assign pc[i] = '0;
      end
   end

   grp_t       grp;
   logic [1:0] idx;
   assign grp = rd_addr_i[4:2];
   assign idx = rd_addr_i[1:0];

   always_comb begin
      rd_val_o = '0;
      case (grp)
         RG_DATA: rd_val_o = pd[idx];
         RG_CTRL: rd_val_o = WORD_W'(pc[idx]);
         RG_GAIN: rd_val_o = pg[idx];
         RG_OFFS: rd_val_o = po[idx];
         RG_SLEW: rd_val_o = WORD_W'(ps[idx]);
         RG_GLOB: begin
            case (idx)
               2'd0:    rd_val_o = status_i;
               2'd1:    rd_val_o = WORD_W'(main_i);
               2'd2:    rd_val_o = WORD_W'(boost_i);
               default: rd_val_o = '0;
            endcase
         end
         default: rd_val_o = '0;
      endcase
   end
endmodule

// File: rtl/qdac_spi_regs.sv
module qdac_spi_regs
   import qdac_pkg::*;
#(
   parameter int NCH         = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  spi_sclk,
   input  logic                  spi_cs_n,
   input  logic                  spi_mosi,
   output logic                  spi_miso,
   input  logic [WORD_W-1:0]     status_i,
   output logic [NCH*WORD_W-1:0] dac_code_o,
   output logic [NCH*WORD_W-1:0] gain_code_o,
   output logic [NCH*WORD_W-1:0] offset_code_o,
   output logic [NCH*CFG_W-1:0]  slew_cfg_o,
   output logic [NCH*CFG_W-1:0]  dac_ctl_o,
   output logic [CFG_W-1:0]      main_cfg_o,
   output logic [CFG_W-1:0]      boost_cfg_o,
   output logic [NCH-1:0]        out_en_o
);
   localparam int PAD_W = FRAME_BITS - WORD_W;

   initial begin
      assert (NCH >= 1 && NCH <= MAX_CH) else $error("NCH must be 1 to 4");
   end

   logic [FRAME_BITS-1:0] frm_word, tx_word;
   logic                  frm_start, frm_end, frm_ok, wr_stb, is_rd;
   logic [ADDR_W-1:0]     frm_addr;
   logic [WORD_W-1:0]     rd_val, rd_word;
   logic                  rd_pend;
   logic                  unused_bits;

   assign is_rd       = frm_word[RD_FLAG_POS];
   assign frm_addr    = frm_word[ADDR_LSB +: ADDR_W];
   assign wr_stb      = frm_ok & ~is_rd;
   assign unused_bits = ^frm_word[RD_FLAG_POS-1:ADDR_LSB+ADDR_W];
   assign tx_word     = rd_pend ? {{PAD_W{1'b0}}, rd_word} : '0;

   qdac_spi_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .sclk_i      (spi_sclk),
      .cs_n_i      (spi_cs_n),
      .mosi_i      (spi_mosi),
      .tx_word_i   (tx_word),
      .miso_o      (spi_miso),
      .frm_start_o (frm_start),
      .frm_end_o   (frm_end),
      .frm_ok_o    (frm_ok),
      .frm_word_o  (frm_word)
   );

   qdac_regs #(.NCH(NCH)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb_i  (wr_stb),
      .wr_addr_i (frm_addr),
      .wr_data_i (frm_word[WORD_W-1:0]),
      .data_o    (dac_code_o),
      .gain_o    (gain_code_o),
      .offs_o    (offset_code_o),
      .slew_o    (slew_cfg_o),
      .dac_o     (dac_ctl_o),
      .main_o    (main_cfg_o),
      .boost_o   (boost_cfg_o)
   );

   qdac_rdmux #(.NCH(NCH)) u_rdmux (
      .rd_addr_i (frm_addr),
      .status_i  (status_i),
      .data_i    (dac_code_o),
      .gain_i    (gain_code_o),
      .offs_i    (offset_code_o),
      .slew_i    (slew_cfg_o),
      .dac_i     (dac_ctl_o),
      .main_i    (main_cfg_o),
      .boost_i   (boost_cfg_o),
      .rd_val_o  (rd_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend <= 1'b0;
         rd_word <= '0;
      end else begin
         if (frm_end) rd_pend <= 1'b0;
         if (frm_ok && is_rd) begin
            rd_pend <= 1'b1;
            rd_word <= rd_val;
         end
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_en
      assign out_en_o[c] = dac_ctl_o[c*CFG_W + OUT_EN_POS];
   end

   // R9
   pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_pend) |-> $past(frm_ok));

   // R9
   quiet_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_start && !rd_pend |=> !spi_miso);
endmodule

// File: tb/qdac_spi_regs_bench.sv
module qdac_spi_regs_bench;
   localparam int NCH  = 4;
   localparam int HALF = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic miso;
   logic [15:0] status = '0;
   logic [NCH*16-1:0] dac_code, gain_code, offset_code;
   logic [NCH*13-1:0] slew_cfg, dac_ctl;
   logic [12:0] main_cfg, boost_cfg;
   logic [NCH-1:0] out_en;

   always #5 clk = ~clk;

   qdac_spi_regs #(.NCH(NCH), .SYNC_STAGES(2)) u_qdac_spi_regs (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .spi_miso(miso), .status_i(status), .dac_code_o(dac_code), .gain_code_o(gain_code),
      .offset_code_o(offset_code), .slew_cfg_o(slew_cfg), .dac_ctl_o(dac_ctl),
      .main_cfg_o(main_cfg), .boost_cfg_o(boost_cfg), .out_en_o(out_en)
   );

   logic [15:0] m_data [NCH];
   logic [15:0] m_gain [NCH];
   logic [15:0] m_off  [NCH];
   logic [12:0] m_slew [NCH];
   logic [12:0] m_dac  [NCH];
   logic [12:0] m_main, m_boost;
   int n_chk = 0, n_err = 0;
   bit done = 0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      for (int c = 0; c < NCH; c++) begin
         check({tag, " data"},   32'(dac_code[c*16 +: 16]),    32'(m_data[c]));
         check({tag, " gain"},   32'(gain_code[c*16 +: 16]),   32'(m_gain[c]));
         check({tag, " offset"}, 32'(offset_code[c*16 +: 16]), 32'(m_off[c]));
         check({tag, " slew"},   32'(slew_cfg[c*13 +: 13]),    32'(m_slew[c]));
         check({tag, " ctl"},    32'(dac_ctl[c*13 +: 13]),     32'(m_dac[c]));
         check({tag, " R11 out_en"}, 32'(out_en[c]),           32'(m_dac[c][6]));
      end
      check({tag, " main"},  32'(main_cfg),  32'(m_main));
      check({tag, " boost"}, 32'(boost_cfg), 32'(m_boost));
   endtask

   task automatic open_frame(input logic [31:0] word, input int nbits, output logic [23:0] got);
      got = '0;
      @(negedge clk) cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int b = nbits - 1; b >= 0; b--) begin
         mosi = word[b];
         repeat (HALF) @(negedge clk);
         got = {got[22:0], miso};
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (HALF) @(negedge clk);
   endtask

   task automatic close_frame();
      cs_n = 1'b1;
      mosi = 1'b0;
      repeat (12) @(negedge clk);
   endtask

   task automatic xfer(input logic [31:0] word, input int nbits, output logic [23:0] got);
      open_frame(word, nbits, got);
      close_frame();
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      logic [23:0] g;
      xfer({8'h00, 3'b000, a, d}, 24, g);
   endtask

   task automatic rd(input logic [4:0] a, input string tag, output logic [15:0] v);
      logic [23:0] g;
      xfer({8'h00, 3'b100, a, 16'h0000}, 24, g);
      xfer(32'h001CE000, 24, g);
      check({tag, " R7 upper byte"}, 32'(g[23:16]), 32'h0);
      v = g[15:0];
   endtask

   function automatic logic [15:0] exp_rd(input logic [4:0] a);
      int c = int'(a[1:0]);
      case (a[4:2])
         3'd0: return m_data[c];
         3'd1: return 16'(m_dac[c]);
         3'd2: return m_gain[c];
         3'd3: return m_off[c];
         3'd5: return 16'(m_slew[c]);
         3'd6: begin
            if (c == 0) return status;
            if (c == 1) return 16'(m_main);
            if (c == 2) return 16'(m_boost);
            return 16'h0;
         end
         default: return 16'h0;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_err++;
         $display("FAIL R1 watchdog actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      logic [23:0] g;
      for (int c = 0; c < NCH; c++) begin
         m_data[c] = '0; m_gain[c] = '0; m_off[c] = '0; m_slew[c] = '0; m_dac[c] = '0;
      end
      m_main = '0; m_boost = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 reset state
      check_all("R1");
      check("R1 miso", 32'(miso), 32'h0);
      rd(5'h00, "R1", v);
      check("R1 read data0", 32'(v), 32'h0);
      rd(5'h19, "R1", v);
      check("R1 read main", 32'(v), 32'h0);

      // R9 quiet MISO with nothing pending
      xfer({8'h00, 3'b000, 5'h0C, 16'hFFFF}, 24, g);
      check("R9 idle miso", 32'(g), 32'h0);

      status = 16'h6B2D;
      for (int p = 0; p < 2; p++) begin
         for (int c = 0; c < NCH; c++) begin
            m_data[c] = 16'((32'h1234 * (c + 1 + 4 * p)) ^ 32'h0F0F);
            m_gain[c] = 16'(32'hFFFF - c * 32'h1111 - p * 32'h0202);
            m_off[c]  = 16'(32'h8000 + c * 32'h0101 + p * 32'h0030);
            m_slew[c] = 13'(32'h1000 | (c * 32'h0123 + p * 7));
            m_dac[c]  = 13'(c | ((((c + p) & 1) != 0) ? 32'h040 : 32'h0) | (p * 32'h100) | 32'h008);
            wr(5'(c), m_data[c]);
            wr(5'(8 + c), m_gain[c]);
            wr(5'(16 + c), m_off[c]);
            wr(5'(28 + c), {3'd0, m_slew[c]});
            wr(5'(28 + c), {3'd2, m_dac[c]});
         end
         m_main  = 13'(32'h0ABC + p);
         m_boost = 13'(32'h0055 + p);
         wr(5'h1E, {3'd1, m_main});
         wr(5'h1D, {3'd3, m_boost});
         check_all("R2 R3 R4");
         for (int a = 0; a < 32; a++) begin
            logic mapped;
            mapped = !((a >= 16 && a <= 19) || (a >= 27) || (a >= 20 && a <= 23 ? 1'b0 : 1'b0));
            rd(5'(a), mapped ? "R7" : "R8", v);
            check(mapped ? "R7 sweep" : "R8 sweep", 32'(v), 32'(exp_rd(5'(a))));
         end
      end

      // R5 ignored writes
      wr(5'h05, 16'hDEAD);
      wr(5'h0D, 16'hBEEF);
      wr(5'h15, 16'h1357);
      wr(5'h18, 16'h2468);
      wr(5'h1B, 16'hFFFF);
      for (int s = 4; s < 8; s++) begin
         wr(5'h1C, {3'(s), 13'h1FFF});
         wr(5'h1F, {3'(s), 13'h0AAA});
      end
      check_all("R5");

      // R6 wrong frame lengths
      xfer({8'h00, 3'b000, 5'h00, 16'h7777}, 23, g);
      xfer({7'h00, 1'b0, 3'b000, 5'h01, 16'h6666}, 25, g);
      xfer({7'h00, 4'b0000, 5'h00, 16'h5555}, 25, g);
      check_all("R6");

      // R10 commit only at chip-select rise
      open_frame({8'h00, 3'b000, 5'h00, 16'h4242}, 24, g);
      repeat (20) @(negedge clk);
      check("R10 before cs rise", 32'(dac_code[15:0]), 32'(m_data[0]));
      close_frame();
      m_data[0] = 16'h4242;
      check("R10 after cs rise", 32'(dac_code[15:0]), 32'h4242);

      // R9 pending read consumed by a discarded frame
      xfer({8'h00, 3'b100, 5'h01, 16'h0000}, 24, g);
      xfer(32'h00ABCDEF, 23, g);
      xfer(32'h001CE000, 24, g);
      check("R9 consumed", 32'(g), 32'h0);

      // R9 write carried in the response frame
      xfer({8'h00, 3'b100, 5'h0A, 16'h0000}, 24, g);
      xfer({8'h00, 3'b000, 5'h02, 16'h3C3C}, 24, g);
      check("R9 R7 response", 32'(g), 32'(m_gain[2]));
      m_data[2] = 16'h3C3C;
      check_all("R9");

      // R12 status captured at request
      status = 16'hA5C3;
      xfer({8'h00, 3'b100, 5'h18, 16'h0000}, 24, g);
      status = 16'h0F0F;
      xfer(32'h001CE000, 24, g);
      check("R12 status", 32'(g), 32'h0000A5C3);

      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule